// File: doc/BRIEF.md
# Video Raster Timing Recovery

This block watches a 10-bit parallel component video stream, one word per pixel clock, and picks out the four-word timing reference sequences that mark the end and the start of active video on every line. From those markers it learns the geometry of the received raster. That geometry is the total words per line, the active words per line, the total lines per frame and the active lines per frame. It also regenerates registered F, V and H timing flags. After one complete frame of observation it declares lock. It then keeps comparing every later line and frame against what it learned, so that it notices when the incoming raster changes.

Each TRS code word re-anchors the counters that depend on it. The line-length counter restarts on every end-of-active marker, and the active-length counter restarts on every start-of-active marker. The line and active-line counters restart on every frame boundary. Both the full 10-bit form and the 8-bit form (two low bits ignored) of the preamble are accepted.

The lock controller is a five-state machine:
- Off: the enable input is low.
- Hunt: waiting for the first frame boundary.
- Measure: recording one full frame.
- Locked: holding the learned raster.
- Suspect: locked, but the previous frame disagreed with the learned raster.

The transitions are:
- enable-high: Off to Hunt.
- first-boundary: Hunt to Measure.
- frame-done: Measure to Locked.
- bad-frame: Locked to Suspect.
- good-frame: Suspect to Locked.
- second-bad-frame: Suspect to Measure.
- enable-low: any state to Off.

Top module: `vtrs_timing_gen`

## Requirements
- R1: While `proc_en` is low, `locked`, the three flag outputs and the four measured outputs are all 0, and TRS codes are ignored. Raising `proc_en` again starts a fresh search with no lock.
- R2: A TRS is the words 0x3FF, 0x000, 0x000 followed by a code word whose bit 9 is 1. In the code word, bit 8 is F, bit 7 is V and bit 6 is H; H=1 marks end of active video and H=0 marks start of active video. The flag outputs take F, V and H at the clock edge that accepts the code word, and they hold those values until the next code word.
- R3: A word from 0x3FC to 0x3FF is accepted as the all-ones preamble word, and a word from 0x000 to 0x003 is accepted as a zero preamble word.
- R4: A four-word group whose preamble is wrong (for example 0x3FB or 0x010 in a preamble slot), or whose code word has bit 9 = 0, leaves the flag outputs unchanged.
- R5: A word presented with `din_vld` low has no effect on any output. Idle gaps between the words of a TRS do not break recognition.
- R6: `line_total` is the number of valid words from one end-of-active code word up to the next one, counting the first and not the second.
- R7: `line_active` is the number of valid words after a start-of-active code word and before the first preamble word of the next end-of-active TRS.
- R8: A frame boundary is an end-of-active TRS whose F falls from 1 to 0. If F=1 has not been seen since enable, a boundary is instead an end-of-active TRS with F=0 whose V rises from 0 to 1. `frame_lines` counts the end-of-active TRS from one boundary up to the next, counting the first and not the second. `frame_active` counts those among them with V=0.
- R9: `locked` rises at the clock edge that accepts the code word of the boundary closing the first full frame after the first boundary seen since enable. All four measured outputs are valid at that edge.
- R10: A frame is bad if any line's measured total or active length differs from the stored value, or if its line or active-line count differs. One bad frame keeps `locked` high and the stored values unchanged. A second consecutive bad frame drops `locked` at the code word of its closing boundary and starts a new one-frame measurement, after which lock returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| proc_en | input | 1 | Enables timing recovery; low holds everything cleared |
| din | input | 10 | Video data word |
| din_vld | input | 1 | Marks `din` as a valid word this cycle |
| trs_f | output | 1 | Regenerated field flag |
| trs_v | output | 1 | Regenerated vertical blanking flag |
| trs_h | output | 1 | Regenerated horizontal flag (1 after end of active video) |
| locked | output | 1 | Raster geometry learned and being tracked |
| line_total | output | 13 | Total words per line |
| line_active | output | 13 | Active words per line |
| frame_lines | output | 11 | Total lines per frame |
| frame_active | output | 11 | Active lines per frame |

## Verification
The marker detector is tried with four kinds of input:
- clean 10-bit codes;
- 8-bit codes carrying noise in their two low bits, which separates masked comparison from exact comparison;
- near-miss groups, which show that recognition needs every preamble word and the code-word marker bit;
- preambles broken by idle cycles, which separate valid-qualified history from cycle-based history.

Geometry learning is driven with a progressive raster and with an interlaced raster of different line length. The interlaced raster shows that V edges inside a field do not count as frame boundaries once F has toggled.

A run of line-length disturbances follows lock. A single bad frame, a good frame, and then two bad frames in a row separate the two-strike rule from both an immediate drop and a never-drop behaviour. A disabled run shows that the enable gates every output.

// File: rtl/vtrs_pkg.sv
package vtrs_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_HUNT,
        ST_MEASURE,
        ST_LOCKED,
        ST_SUSPECT
    } lock_state_e;

    typedef struct packed {
        logic f;
        logic v;
        logic h;
    } trs_flags_t;

endpackage

// File: rtl/vtrs_trs_detect.sv
module vtrs_trs_detect
    import vtrs_pkg::*;
#(
    parameter int DATA_W      = 10,
    parameter bit ACCEPT_8BIT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              vld,
    input  logic [DATA_W-1:0] din,
    output logic              hit,
    output trs_flags_t        flags
);

    localparam int CMP_LSB = ACCEPT_8BIT ? 2 : 0;
    localparam int CMP_W   = DATA_W - CMP_LSB;
    localparam int HIST    = 3;

    logic [CMP_W-1:0] cmp_bits;
    logic             is_ones;
    logic             is_zero;
    logic [HIST-1:0]  ones_q;
    logic [HIST-1:0]  zero_q;

    // Select the compared slice: 8-bit tolerant codes drop the two low bits
    generate
        if (ACCEPT_8BIT) begin : g_masked
            assign cmp_bits = din[DATA_W-1:CMP_LSB];
        end else begin : g_exact
            assign cmp_bits = din;
        end
    endgenerate

    assign is_ones = &cmp_bits;
    assign is_zero = ~|cmp_bits;

    // History of valid words only; idle cycles do not shift it
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            ones_q <= '0;
            zero_q <= '0;
        end else if (vld) begin
            ones_q <= {ones_q[HIST-2:0], is_ones};
            zero_q <= {zero_q[HIST-2:0], is_zero};
        end
    end

    assign hit = en && vld && din[DATA_W-1] && ones_q[HIST-1]
                 && zero_q[1] && zero_q[0];

    assign flags.f = din[DATA_W-2];
    assign flags.v = din[DATA_W-3];
    assign flags.h = din[DATA_W-4];

endmodule

// File: rtl/vtrs_pix_meas.sv
module vtrs_pix_meas #(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             vld,
    input  logic             hit,
    input  logic             is_eav,
    output logic             tot_stb,
    output logic [CNT_W-1:0] tot_len,
    output logic             act_stb,
    output logic [CNT_W-1:0] act_len
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);
    localparam logic [CNT_W-1:0] PRE_LEN = CNT_W'(3);

    logic [CNT_W-1:0] cnt_eav;
    logic [CNT_W-1:0] cnt_sav;
    logic             have_eav;
    logic             sav_seen;
    logic [CNT_W-1:0] eav_inc;
    logic [CNT_W-1:0] sav_inc;

    assign eav_inc = (cnt_eav == CNT_MAX) ? cnt_eav : cnt_eav + ONE;
    assign sav_inc = (cnt_sav == CNT_MAX) ? cnt_sav : cnt_sav + ONE;

    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt_eav  <= '0;
            cnt_sav  <= '0;
            have_eav <= 1'b0;
            sav_seen <= 1'b0;
        end else if (vld) begin
            if (hit && is_eav) begin
                cnt_eav  <= '0;
                have_eav <= 1'b1;
                sav_seen <= 1'b0;
                cnt_sav  <= sav_inc;
            end else if (hit) begin
                cnt_sav  <= '0;
                sav_seen <= 1'b1;
                cnt_eav  <= eav_inc;
            end else begin
                cnt_eav  <= eav_inc;
                cnt_sav  <= sav_inc;
            end
        end
    end

    assign tot_stb = hit && is_eav && have_eav;
    assign tot_len = cnt_eav + ONE;
    assign act_stb = hit && is_eav && sav_seen && (cnt_sav >= PRE_LEN);
    assign act_len = cnt_sav - PRE_LEN;

endmodule

// File: rtl/vtrs_line_meas.sv
module vtrs_line_meas #(
    parameter int LN_W = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            eav_stb,
    input  logic            f,
    input  logic            v,
    output logic            frame_stb,
    output logic [LN_W-1:0] lines_total,
    output logic [LN_W-1:0] lines_active
);

    localparam logic [LN_W-1:0] LN_ONE = LN_W'(1);

    logic            prev_f;
    logic            prev_v;
    logic            have_prev;
    logic            f_seen;
    logic [LN_W-1:0] ln_cnt;
    logic [LN_W-1:0] act_cnt;
    logic [LN_W-1:0] act_add;

    assign act_add   = {{(LN_W-1){1'b0}}, ~v};
    assign frame_stb = eav_stb && have_prev &&
                       ((prev_f && !f) || (!f_seen && !f && !prev_v && v));

    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            prev_f    <= 1'b0;
            prev_v    <= 1'b0;
            have_prev <= 1'b0;
            f_seen    <= 1'b0;
            ln_cnt    <= '0;
            act_cnt   <= '0;
        end else if (eav_stb) begin
            prev_f    <= f;
            prev_v    <= v;
            have_prev <= 1'b1;
            if (f) f_seen <= 1'b1;
            if (frame_stb) begin
                ln_cnt  <= LN_ONE;
                act_cnt <= act_add;
            end else begin
                ln_cnt  <= ln_cnt + LN_ONE;
                act_cnt <= act_cnt + act_add;
            end
        end
    end

    assign lines_total  = ln_cnt;
    assign lines_active = act_cnt;

endmodule

// File: rtl/vtrs_lock_fsm.sv
module vtrs_lock_fsm
    import vtrs_pkg::*;
#(
    parameter int CNT_W = 13,
    parameter int LN_W  = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             frame_stb,
    input  logic             tot_stb,
    input  logic [CNT_W-1:0] tot_len,
    input  logic             act_stb,
    input  logic [CNT_W-1:0] act_len,
    input  logic [LN_W-1:0]  lines_total,
    input  logic [LN_W-1:0]  lines_active,
    output logic             locked,
    output logic [CNT_W-1:0] line_total,
    output logic [CNT_W-1:0] line_active,
    output logic [LN_W-1:0]  frame_lines,
    output logic [LN_W-1:0]  frame_active
);

    lock_state_e      state_q;
    lock_state_e      state_d;
    logic             frame_bad_q;
    logic             line_mis;
    logic             count_mis;
    logic             bad_frame;
    logic [CNT_W-1:0] line_total_q;
    logic [CNT_W-1:0] line_active_q;
    logic [LN_W-1:0]  frame_lines_q;
    logic [LN_W-1:0]  frame_active_q;

    assign line_mis  = (tot_stb && (tot_len != line_total_q)) ||
                       (act_stb && (act_len != line_active_q));
    assign count_mis = (lines_total != frame_lines_q) ||
                       (lines_active != frame_active_q);
    assign bad_frame = frame_bad_q || line_mis || count_mis;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        if (!en) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:     state_d = ST_HUNT;
                ST_HUNT:    if (frame_stb) state_d = ST_MEASURE;
                ST_MEASURE: if (frame_stb) state_d = ST_LOCKED;
                ST_LOCKED:  if (frame_stb && bad_frame) state_d = ST_SUSPECT;
                ST_SUSPECT: if (frame_stb) state_d = bad_frame ? ST_MEASURE : ST_LOCKED;
            endcase
        end
    end

    // Stored geometry and frame quality
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            line_total_q   <= '0;
            line_active_q  <= '0;
            frame_lines_q  <= '0;
            frame_active_q <= '0;
            frame_bad_q    <= 1'b0;
        end else begin
            unique case (state_q)
                ST_MEASURE: begin
                    if (tot_stb) line_total_q  <= tot_len;
                    if (act_stb) line_active_q <= act_len;
                    if (frame_stb) begin
                        frame_lines_q  <= lines_total;
                        frame_active_q <= lines_active;
                    end
                    frame_bad_q <= 1'b0;
                end
                ST_LOCKED, ST_SUSPECT: begin
                    if (frame_stb)     frame_bad_q <= 1'b0;
                    else if (line_mis) frame_bad_q <= 1'b1;
                end
                ST_OFF, ST_HUNT: frame_bad_q <= 1'b0;
            endcase
        end
    end

    assign locked       = (state_q == ST_LOCKED) || (state_q == ST_SUSPECT);
    assign line_total   = line_total_q;
    assign line_active  = line_active_q;
    assign frame_lines  = frame_lines_q;
    assign frame_active = frame_active_q;

endmodule

// File: rtl/vtrs_timing_gen.sv
module vtrs_timing_gen
    import vtrs_pkg::*;
#(
    parameter int DATA_W      = 10,
    parameter int CNT_W       = 13,
    parameter int LN_W        = 11,
    parameter bit ACCEPT_8BIT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              proc_en,
    input  logic [DATA_W-1:0] din,
    input  logic              din_vld,
    output logic              trs_f,
    output logic              trs_v,
    output logic              trs_h,
    output logic              locked,
    output logic [CNT_W-1:0]  line_total,
    output logic [CNT_W-1:0]  line_active,
    output logic [LN_W-1:0]   frame_lines,
    output logic [LN_W-1:0]   frame_active
);

    logic             xyz_hit;
    trs_flags_t       det_flags;
    trs_flags_t       flags_q;
    logic             eav_stb;
    logic             frame_stb;
    logic             tot_stb;
    logic             act_stb;
    logic [CNT_W-1:0] tot_len;
    logic [CNT_W-1:0] act_len;
    logic [LN_W-1:0]  lines_total;
    logic [LN_W-1:0]  lines_active;

    vtrs_trs_detect #(.DATA_W(DATA_W), .ACCEPT_8BIT(ACCEPT_8BIT)) det_i (
        .clk(clk), .rst_n(rst_n), .en(proc_en), .vld(din_vld), .din(din),
        .hit(xyz_hit), .flags(det_flags)
    );

    assign eav_stb = xyz_hit && det_flags.h;

    vtrs_pix_meas #(.CNT_W(CNT_W)) pix_i (
        .clk(clk), .rst_n(rst_n), .en(proc_en), .vld(din_vld), .hit(xyz_hit),
        .is_eav(det_flags.h), .tot_stb(tot_stb), .tot_len(tot_len),
        .act_stb(act_stb), .act_len(act_len)
    );

    vtrs_line_meas #(.LN_W(LN_W)) line_i (
        .clk(clk), .rst_n(rst_n), .en(proc_en), .eav_stb(eav_stb),
        .f(det_flags.f), .v(det_flags.v), .frame_stb(frame_stb),
        .lines_total(lines_total), .lines_active(lines_active)
    );

    vtrs_lock_fsm #(.CNT_W(CNT_W), .LN_W(LN_W)) fsm_i (
        .clk(clk), .rst_n(rst_n), .en(proc_en), .frame_stb(frame_stb),
        .tot_stb(tot_stb), .tot_len(tot_len), .act_stb(act_stb), .act_len(act_len),
        .lines_total(lines_total), .lines_active(lines_active), .locked(locked),
        .line_total(line_total), .line_active(line_active),
        .frame_lines(frame_lines), .frame_active(frame_active)
    );

    // Regenerated flags, registered on the code word
    always_ff @(posedge clk) begin
        if (!rst_n || !proc_en) flags_q <= '0;
        else if (xyz_hit)       flags_q <= det_flags;
    end

    assign trs_f = flags_q.f;
    assign trs_v = flags_q.v;
    assign trs_h = flags_q.h;

endmodule

// File: rtl/vtrs_timing_chk.sv
module vtrs_timing_chk #(
    parameter int CNT_W = 13,
    parameter int LN_W  = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             proc_en,
    input logic             din_vld,
    input logic             xyz_hit,
    input logic             trs_f,
    input logic             trs_v,
    input logic             trs_h,
    input logic             locked,
    input logic [CNT_W-1:0] line_total,
    input logic [CNT_W-1:0] line_active,
    input logic [LN_W-1:0]  frame_lines,
    input logic [LN_W-1:0]  frame_active
);

    a_r1_disable_drops_lock: assert property (@(posedge clk) disable iff (!rst_n)
        !proc_en |=> !locked);

    a_r1_disable_clears_flags: assert property (@(posedge clk) disable iff (!rst_n)
        !proc_en |=> ({trs_f, trs_v, trs_h} == 3'b000));

    a_r2_flags_hold_between_codes: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_en && !xyz_hit) ##1 proc_en |-> $stable({trs_f, trs_v, trs_h}));

    a_r5_idle_word_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_en && !din_vld) ##1 proc_en |->
            $stable({locked, line_total, line_active, frame_lines, frame_active}));

    a_r9_lock_rises_on_code: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(xyz_hit));

    a_r10_lock_falls_on_code: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(locked) && $past(proc_en)) |-> $past(xyz_hit));

    a_r8_locked_has_frame: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> (frame_lines != '0));

endmodule

bind vtrs_timing_gen vtrs_timing_chk #(.CNT_W(CNT_W), .LN_W(LN_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .proc_en(proc_en), .din_vld(din_vld),
    .xyz_hit(xyz_hit), .trs_f(trs_f), .trs_v(trs_v), .trs_h(trs_h),
    .locked(locked), .line_total(line_total), .line_active(line_active),
    .frame_lines(frame_lines), .frame_active(frame_active)
);

// File: tb/vtrs_timing_gen_tb_top.sv
module vtrs_timing_gen_tb_top;

    localparam int DATA_W = 10;
    localparam int CNT_W  = 13;
    localparam int LN_W   = 11;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              proc_en = 1'b0;
    logic [DATA_W-1:0] din = 10'h200;
    logic              din_vld = 1'b0;
    logic              trs_f, trs_v, trs_h, locked;
    logic [CNT_W-1:0]  line_total, line_active;
    logic [LN_W-1:0]   frame_lines, frame_active;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    vtrs_timing_gen dut_i (
        .clk(clk), .rst_n(rst_n), .proc_en(proc_en), .din(din), .din_vld(din_vld),
        .trs_f(trs_f), .trs_v(trs_v), .trs_h(trs_h), .locked(locked),
        .line_total(line_total), .line_active(line_active),
        .frame_lines(frame_lines), .frame_active(frame_active)
    );

    task automatic chk_eq(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    function automatic logic [9:0] code(input bit f, input bit v, input bit h);
        return 10'h200 | (10'(f) << 8) | (10'(v) << 7) | (10'(h) << 6);
    endfunction

    function automatic int flags3();
        return int'({trs_f, trs_v, trs_h});
    endfunction

    task automatic send_word(input logic [9:0] w);
        @(negedge clk);
        din = w;
        din_vld = 1'b1;
    endtask

    // One idle cycle; outputs after the previous word are then stable
    task automatic idle_sample();
        @(negedge clk);
        din_vld = 1'b0;
        din = 10'h200;
    endtask

    task automatic send_trs(input bit f, input bit v, input bit h);
        send_word(10'h3FF); send_word(10'h000); send_word(10'h000);
        send_word(code(f, v, h));
    endtask

    // Words after the end-of-active code: blanking, start-of-active TRS, active
    task automatic send_body(input int len, input int act, input bit f, input bit v);
        for (int i = 0; i < len - 8 - act; i++) send_word(10'h200);
        send_trs(f, v, 1'b0);
        for (int i = 0; i < act; i++) send_word(10'h0C8);
    endtask

    function automatic bit prog_v(input int ln);
        return (ln <= 2) || (ln >= 9);
    endfunction

    task automatic prog_line(input int ln, input int len);
        send_trs(1'b0, prog_v(ln), 1'b1);
        send_body(len, 16, 1'b0, prog_v(ln));
    endtask

    function automatic bit il_f(input int ln);
        return ln >= 6;
    endfunction

    function automatic bit il_v(input int ln);
        return (ln == 1) || (ln == 5) || (ln == 6) || (ln == 10);
    endfunction

    task automatic il_line(input int ln);
        send_trs(il_f(ln), il_v(ln), 1'b1);
        send_body(40, 24, il_f(ln), il_v(ln));
    endtask

    task automatic restart_en();
        idle_sample();
        proc_en = 1'b0;
        repeat (3) idle_sample();
        proc_en = 1'b1;
        idle_sample();
    endtask

    task automatic t_reset_state();
        idle_sample();
        chk_eq("R1 reset locked", int'(locked), 0);
        chk_eq("R1 reset flags", flags3(), 0);
        chk_eq("R1 reset line_total", int'(line_total), 0);
    endtask

    task automatic t_disabled();
        proc_en = 1'b0;
        for (int r = 0; r < 2; r++)
            for (int ln = 1; ln <= 10; ln++) prog_line(ln, 32);
        send_trs(1'b1, 1'b1, 1'b1);
        idle_sample();
        chk_eq("R1 disabled flags", flags3(), 0);
        chk_eq("R1 disabled locked", int'(locked), 0);
        chk_eq("R1 disabled frame_lines", int'(frame_lines), 0);
        chk_eq("R1 disabled line_total", int'(line_total), 0);
    endtask

    task automatic t_flags_10bit();
        proc_en = 1'b1;
        idle_sample();
        send_trs(1'b1, 1'b1, 1'b1);
        idle_sample();
        chk_eq("R2 flags after F1 V1 H1 code", flags3(), 7);
        send_word(10'h200); send_word(10'h0C8);
        idle_sample();
        chk_eq("R2 flags hold on data words", flags3(), 7);
        send_trs(1'b0, 1'b0, 1'b0);
        idle_sample();
        chk_eq("R2 flags after F0 V0 H0 code", flags3(), 0);
    endtask

    task automatic t_near_miss();
        send_word(10'h3FF); send_word(10'h000); send_word(10'h000); send_word(10'h1C0);
        idle_sample();
        chk_eq("R4 code bit9 low ignored", flags3(), 0);
        send_word(10'h3FF); send_word(10'h010); send_word(10'h000); send_word(10'h3C0);
        idle_sample();
        chk_eq("R4 bad zero word ignored", flags3(), 0);
        send_word(10'h3FB); send_word(10'h000); send_word(10'h000); send_word(10'h3C0);
        idle_sample();
        chk_eq("R4 bad ones word ignored", flags3(), 0);
    endtask

    task automatic t_eight_bit();
        send_word(10'h3FC); send_word(10'h002); send_word(10'h001); send_word(code(0, 1, 1));
        idle_sample();
        chk_eq("R3 8-bit preamble accepted", flags3(), 3);
    endtask

    task automatic t_gaps();
        send_word(10'h3FF); idle_sample();
        send_word(10'h000); idle_sample(); idle_sample();
        send_word(10'h000); idle_sample();
        send_word(code(1, 0, 1));
        idle_sample();
        chk_eq("R5 preamble with idle gaps", flags3(), 5);
    endtask

    task automatic t_prog_lock_and_drop();
        restart_en();
        chk_eq("R1 re-enable starts unlocked", int'(locked), 0);
        for (int ln = 1; ln <= 10; ln++) prog_line(ln, 32);
        for (int ln = 1; ln <= 8; ln++) prog_line(ln, 32);
        idle_sample();
        chk_eq("R9 no lock before frame closes", int'(locked), 0);
        send_trs(1'b0, 1'b1, 1'b1);
        idle_sample();
        chk_eq("R9 lock at closing boundary", int'(locked), 1);
        chk_eq("R6 progressive line_total", int'(line_total), 32);
        chk_eq("R7 progressive line_active", int'(line_active), 16);
        chk_eq("R8 progressive frame_lines", int'(frame_lines), 10);
        chk_eq("R8 progressive frame_active", int'(frame_active), 6);
        // Window A: bad
        send_body(36, 16, 1'b0, 1'b1);
        prog_line(10, 36);
        for (int ln = 1; ln <= 8; ln++) prog_line(ln, 36);
        send_trs(1'b0, 1'b1, 1'b1);
        idle_sample();
        chk_eq("R10 one bad frame keeps lock", int'(locked), 1);
        chk_eq("R10 stored line_total kept", int'(line_total), 32);
        // Window B: good
        send_body(32, 16, 1'b0, 1'b1);
        prog_line(10, 32);
        for (int ln = 1; ln <= 8; ln++) prog_line(ln, 32);
        send_trs(1'b0, 1'b1, 1'b1);
        idle_sample();
        chk_eq("R10 good frame keeps lock", int'(locked), 1);
        // Windows C and D: bad twice
        for (int w = 0; w < 2; w++) begin
            send_body(36, 16, 1'b0, 1'b1);
            prog_line(10, 36);
            for (int ln = 1; ln <= 8; ln++) prog_line(ln, 36);
            send_trs(1'b0, 1'b1, 1'b1);
            idle_sample();
            chk_eq(w == 0 ? "R10 first of two bad keeps lock" : "R10 second bad drops lock",
                   int'(locked), (w == 0) ? 1 : 0);
        end
        // Window E: remeasure
        send_body(32, 16, 1'b0, 1'b1);
        prog_line(10, 32);
        for (int ln = 1; ln <= 8; ln++) prog_line(ln, 32);
        idle_sample();
        chk_eq("R10 still unlocked during remeasure", int'(locked), 0);
        send_trs(1'b0, 1'b1, 1'b1);
        idle_sample();
        chk_eq("R10 relock after remeasure", int'(locked), 1);
        chk_eq("R10 relearned line_total", int'(line_total), 32);
    endtask

    task automatic t_interlaced();
        restart_en();
        for (int ln = 6; ln <= 10; ln++) il_line(ln);
        for (int ln = 1; ln <= 10; ln++) il_line(ln);
        idle_sample();
        chk_eq("R8 V edge inside field is no boundary", int'(locked), 0);
        send_trs(1'b0, 1'b1, 1'b1);
        idle_sample();
        chk_eq("R9 interlaced lock on F fall", int'(locked), 1);
        chk_eq("R8 interlaced frame_lines", int'(frame_lines), 10);
        chk_eq("R8 interlaced frame_active", int'(frame_active), 6);
        chk_eq("R6 interlaced line_total", int'(line_total), 40);
        chk_eq("R7 interlaced line_active", int'(line_active), 24);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset_state();
        rst_n = 1'b1;
        t_reset_state();
        t_disabled();
        t_flags_10bit();
        t_near_miss();
        t_eight_bit();
        t_gaps();
        t_prog_lock_and_drop();
        t_interlaced();
        report();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: run did not complete");
        report();
    end

endmodule